// File: doc/BRIEF.md
# Parallel Dense Layer with Rectified Outputs

This block evaluates one fully connected neural-network layer with every neuron working at once. After a start pulse it takes an input vector as a stream, one signed 16-bit element per accepted transfer, and offers each element to all neurons together. Each neuron multiplies the element by its own signed 8-bit weight and adds the product to a private 32-bit signed accumulator. One cycle after the last element, every neuron adds its own sign-extended 8-bit bias. One further cycle later a registered rectifier captures the results, and a single-cycle valid pulse announces them.

The input count and neuron count are parameters, so one design serves both a wide hidden layer and a narrow output layer. Weights and biases sit in a small internal array that is loaded through a plain write port before a run. One row is read per cycle and holds one byte per neuron. Each rectified result is offered at full 32-bit width and also clamped to a signed 16-bit value that a following layer can take directly as its input.

Back-pressure rules: the input side is valid/ready. `in_ready` is high only while the layer still expects elements, and a transfer takes place on a rising edge where `in_valid` and `in_ready` are both high. The source may hold `in_valid` low to stall, and nothing is lost. The output side has no ready: results are presented with `out_valid` for one cycle and then held until the next run completes.

Top module: `dense_layer`

## Requirements
- R1: After reset `out_valid` and `in_ready` are low and every field of `out_act` and `out_sat` is zero.
- R2: A rising edge with `prm_we` high stores `prm_data` as the weight of input `prm_row` for neuron `prm_col` when `prm_row` < N_IN. Row N_IN holds the biases. A write with `prm_row` > N_IN or `prm_col` >= N_NEU changes nothing.
- R3: `start` seen while the layer is idle clears all accumulators, and `in_ready` is high in the next cycle. `start` seen while a run is in progress has no effect on that run's results.
- R4: The k-th accepted transfer (k counted from 0) adds `in_data` times weight row k to each neuron's accumulator, using signed arithmetic throughout.
- R5: While `in_ready` is high and `in_valid` is low, nothing is accumulated, the element index holds and `in_ready` stays high.
- R6: After the N_IN-th accepted transfer `in_ready` drops. In the next cycle each neuron adds its own sign-extended bias, exactly once.
- R7: `out_valid` is a one-cycle pulse. With no stalls it is high in the cycle after the (N_IN+2)-th rising edge that follows the edge on which `start` was taken, and each stall cycle delays it by one. `out_act` and `out_sat` change only on the edge that raises `out_valid`, and hold their values otherwise.
- R8: Neuron j's field of `out_act` (bits 32j+31 down to 32j) equals its final accumulator value when that is non-negative, and 0 otherwise.
- R9: Neuron j's field of `out_sat` (bits 16j+15 down to 16j) equals its `out_act` value when that is at most 32767, and 32767 otherwise.
- R10: `in_valid` asserted while the layer is idle has no effect: `in_ready` stays low and the next run's results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| prm_we | input | 1 | Parameter write strobe |
| prm_row | input | ROW_W | Parameter row: input index, or N_IN for the bias row |
| prm_col | input | COL_W | Parameter column: neuron index |
| prm_data | input | WGT_W | Signed weight or bias byte |
| start | input | 1 | Begin a run; taken only when idle |
| in_valid | input | 1 | Input element is valid |
| in_ready | output | 1 | Layer accepts an input element |
| in_data | input | ACT_W | Signed input element |
| out_valid | output | 1 | One-cycle pulse: results updated |
| out_act | output | N_NEU*ACC_W | Rectified 32-bit results, neuron j in slice j |
| out_sat | output | N_NEU*ACT_W | Results clamped to 0..32767, neuron j in slice j |

## Verification
The bench builds the layer with five inputs and four neurons. At this size a full reload of weights and biases costs only 24 writes, so every run uses a fresh parameter set. Extreme operands (±32767/−32768 against 127/−128), pseudo-random sets and an exact 32767/32768 clamp boundary are all reachable in a few hundred cycles. Because the row count of six is not a power of two, row addresses past the bias row exist and can be written to test that such writes are ignored. The short input vector also makes it cheap to count latency cycle by cycle with and without a stall, and with a start pulse injected mid-run.

// File: rtl/dense_pkg.sv
package dense_pkg;
  localparam int DFLT_WGT_W = 8;
  localparam int DFLT_ACT_W = 16;
  localparam int DFLT_ACC_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_BIAS = 2'd2,
    ST_DONE = 2'd3
  } layer_state_t;
endpackage

// File: rtl/dense_param_store.sv
module dense_param_store #(
  parameter int N_IN  = 32,
  parameter int N_NEU = 10,
  parameter int WGT_W = 8,
  parameter int ROW_W = 6,
  parameter int COL_W = 4
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [ROW_W-1:0]       wr_row,
  input  logic [COL_W-1:0]       wr_col,
  input  logic [WGT_W-1:0]       wr_data,
  input  logic [ROW_W-1:0]       rd_row,
  output logic [N_NEU*WGT_W-1:0] rd_word
);
  localparam int N_ROWS = N_IN + 1;

  logic [N_NEU*WGT_W-1:0] mem [N_ROWS];
  logic                   wr_ok;

  assign wr_ok = wr_en && (int'(wr_row) < N_ROWS) && (int'(wr_col) < N_NEU);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wr_row][int'(wr_col)*WGT_W +: WGT_W] <= wr_data;
    end
  end

  assign rd_word = mem[rd_row];
endmodule

// File: rtl/dense_seq.sv
module dense_seq
  import dense_pkg::*;
#(
  parameter int N_IN  = 32,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             clr,
  output logic             mac_en,
  output logic             bias_en,
  output logic             load_en,
  output logic             out_valid,
  output logic [ROW_W-1:0] rd_row
);
  localparam logic [ROW_W-1:0] LAST_IDX = ROW_W'(N_IN - 1);
  localparam logic [ROW_W-1:0] BIAS_ROW = ROW_W'(N_IN);

  layer_state_t     st;
  logic [ROW_W-1:0] idx;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= (st == ST_DONE);
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st  <= ST_ACC;
            idx <= '0;
          end
        end
        ST_ACC: begin
          if (in_valid) begin
            if (idx == LAST_IDX) st <= ST_BIAS;
            idx <= idx + 1'b1;
          end
        end
        ST_BIAS: st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    in_ready  = (st == ST_ACC);
    clr       = (st == ST_IDLE) && start;
    mac_en    = in_ready && in_valid;
    bias_en   = (st == ST_BIAS);
    load_en   = (st == ST_DONE);
    rd_row    = bias_en ? BIAS_ROW : idx;
    out_valid = vld_q;
  end
endmodule

// File: rtl/dense_neuron.sv
module dense_neuron #(
  parameter int WGT_W = 8,
  parameter int ACT_W = 16,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mac_en,
  input  logic             bias_en,
  input  logic             load_en,
  input  logic [ACT_W-1:0] x,
  input  logic [WGT_W-1:0] w,
  output logic [ACC_W-1:0] act_o,
  output logic [ACT_W-1:0] sat_o
);
  localparam logic [ACC_W-1:0] SAT_MAX = ACC_W'((1 << (ACT_W - 1)) - 1);

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] w_ext;
  logic signed [ACC_W-1:0] prod;
  logic        [ACC_W-1:0] rect_q;

  always_comb begin
    x_ext = ACC_W'($signed(x));
    w_ext = ACC_W'($signed(w));
    prod  = x_ext * w_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (mac_en) begin
      acc <= acc + prod;
    end else if (bias_en) begin
      acc <= acc + w_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rect_q <= '0;
    end else if (load_en) begin
      rect_q <= acc[ACC_W-1] ? '0 : acc;
    end
  end

  assign act_o = rect_q;
  assign sat_o = (rect_q > SAT_MAX) ? SAT_MAX[ACT_W-1:0] : rect_q[ACT_W-1:0];
endmodule

// File: rtl/dense_layer.sv
module dense_layer
  import dense_pkg::*;
#(
  parameter int N_IN  = 32,
  parameter int N_NEU = 10,
  parameter int WGT_W = DFLT_WGT_W,
  parameter int ACT_W = DFLT_ACT_W,
  parameter int ACC_W = DFLT_ACC_W,
  parameter int ROW_W = $clog2(N_IN + 1),
  parameter int COL_W = (N_NEU > 1) ? $clog2(N_NEU) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prm_we,
  input  logic [ROW_W-1:0]       prm_row,
  input  logic [COL_W-1:0]       prm_col,
  input  logic [WGT_W-1:0]       prm_data,
  input  logic                   start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [ACT_W-1:0]       in_data,
  output logic                   out_valid,
  output logic [N_NEU*ACC_W-1:0] out_act,
  output logic [N_NEU*ACT_W-1:0] out_sat
);
  logic                   clr;
  logic                   mac_en;
  logic                   bias_en;
  logic                   load_en;
  logic [ROW_W-1:0]       rd_row;
  logic [N_NEU*WGT_W-1:0] rd_word;

  dense_seq #(
    .N_IN  (N_IN),
    .ROW_W (ROW_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .clr       (clr),
    .mac_en    (mac_en),
    .bias_en   (bias_en),
    .load_en   (load_en),
    .out_valid (out_valid),
    .rd_row    (rd_row)
  );

  dense_param_store #(
    .N_IN  (N_IN),
    .N_NEU (N_NEU),
    .WGT_W (WGT_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (prm_we),
    .wr_row  (prm_row),
    .wr_col  (prm_col),
    .wr_data (prm_data),
    .rd_row  (rd_row),
    .rd_word (rd_word)
  );

  for (genvar j = 0; j < N_NEU; j++) begin : g_neu
    dense_neuron #(
      .WGT_W (WGT_W),
      .ACT_W (ACT_W),
      .ACC_W (ACC_W)
    ) u_neu (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .mac_en  (mac_en),
      .bias_en (bias_en),
      .load_en (load_en),
      .x       (in_data),
      .w       (rd_word[j*WGT_W +: WGT_W]),
      .act_o   (out_act[j*ACC_W +: ACC_W]),
      .sat_o   (out_sat[j*ACT_W +: ACT_W])
    );
  end
endmodule

// File: rtl/dense_layer_chk.sv
module dense_layer_chk #(
  parameter int N_IN  = 32,
  parameter int N_NEU = 10,
  parameter int ACT_W = 16,
  parameter int ACC_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic [N_NEU*ACC_W-1:0] out_act,
  input logic [N_NEU*ACT_W-1:0] out_sat
);
  int unsigned acc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_cnt <= 0;
    else if (!in_ready) acc_cnt <= 0;
    else if (in_valid) acc_cnt <= acc_cnt + 1;
  end

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_act != $past(out_act)) |-> out_valid);

  p_ready_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |-> (acc_cnt < N_IN));

  p_done_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> ##2 out_valid);

  for (genvar j = 0; j < N_NEU; j++) begin : g_chk
    p_nonneg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_act[j*ACC_W + ACC_W - 1]);

    p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_sat[j*ACT_W + ACT_W - 1] &&
      (ACC_W'(out_sat[j*ACT_W +: ACT_W]) <= out_act[j*ACC_W +: ACC_W]));
  end
endmodule

bind dense_layer dense_layer_chk #(
  .N_IN  (N_IN),
  .N_NEU (N_NEU),
  .ACT_W (ACT_W),
  .ACC_W (ACC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_act   (out_act),
  .out_sat   (out_sat)
);

// File: tb/tb_dense_layer.sv
module tb_dense_layer;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 5;
  localparam int NN = 4;
  localparam int RW = $clog2(NI + 1);
  localparam int CW = $clog2(NN);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              prm_we = 1'b0;
  logic [RW-1:0]     prm_row = '0;
  logic [CW-1:0]     prm_col = '0;
  logic [7:0]        prm_data = '0;
  logic              start = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [15:0]       in_data = '0;
  logic              out_valid;
  logic [NN*32-1:0]  out_act;
  logic [NN*16-1:0]  out_sat;

  int n_chk = 0;
  int n_fail = 0;
  int xin [NI];
  int wt  [NI+1][NN];
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  dense_layer #(.N_IN(NI), .N_NEU(NN)) dut (
    .clk(clk), .rst_n(rst_n), .prm_we(prm_we), .prm_row(prm_row),
    .prm_col(prm_col), .prm_data(prm_data), .start(start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_act(out_act), .out_sat(out_sat)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(input int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % span);
  endfunction

  task automatic wr(input int row, input int col, input int val);
    @(negedge clk);
    prm_we = 1'b1; prm_row = RW'(row); prm_col = CW'(col); prm_data = 8'(val);
    @(negedge clk);
    prm_we = 1'b0;
  endtask

  task automatic load_all();
    for (int r = 0; r <= NI; r++)
      for (int c = 0; c < NN; c++) wr(r, c, wt[r][c]);
  endtask

  task automatic check_results(input string tag);
    for (int j = 0; j < NN; j++) begin
      longint s = wt[NI][j];
      longint r, q;
      for (int i = 0; i < NI; i++) s += longint'(xin[i]) * wt[i][j];
      r = (s < 0) ? 0 : s;
      q = (r > 32767) ? 32767 : r;
      chk(out_act[j*32 +: 32] == 32'(r), {tag, " R4 R6 R8 act"}, longint'($signed(out_act[j*32 +: 32])), r);
      chk(out_sat[j*16 +: 16] == 16'(q), {tag, " R9 sat"}, longint'(out_sat[j*16 +: 16]), q);
    end
  endtask

  // stall_at < 0 means no stall; poke injects start during the stall cycle
  task automatic run(input int stall_at, input bit poke, input string tag);
    int lat;
    logic [NN*32-1:0] held;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    chk(in_ready == 1'b1, {tag, " R3 ready after start"}, in_ready, 1);
    lat = 0;
    for (int i = 0; i < NI; i++) begin
      if (i == stall_at) begin
        in_valid = 1'b0; in_data = 16'h7fff; start = poke;
        @(negedge clk);
        start = 1'b0; lat++;
        chk(in_ready == 1'b1, {tag, " R5 ready held in stall"}, in_ready, 1);
      end
      in_valid = 1'b1; in_data = 16'(xin[i]);
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0; in_data = 16'h8000;
    chk(in_ready == 1'b0, {tag, " R6 ready drops"}, in_ready, 0);
    chk(out_valid == 1'b0, {tag, " R7 no early valid"}, out_valid, 0);
    while (!out_valid && lat < NI + 10) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == NI + 2 + ((stall_at >= 0) ? 1 : 0), {tag, " R7 latency"}, lat,
        NI + 2 + ((stall_at >= 0) ? 1 : 0));
    check_results(tag);
    held = out_act;
    @(negedge clk);
    chk(out_valid == 1'b0, {tag, " R7 pulse width"}, out_valid, 0);
    repeat (2) @(negedge clk);
    chk(out_act == held, {tag, " R7 outputs held"}, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R1 reset control", {out_valid, in_ready}, 0);
    chk(out_act == '0 && out_sat == '0, "R1 reset data", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // p0: all max positive -> clamp
    for (int i = 0; i < NI; i++) xin[i] = 32767;
    for (int r = 0; r <= NI; r++) for (int c = 0; c < NN; c++) wt[r][c] = 127;
    load_all(); run(-1, 0, "p0");
    // p1: negative sums -> rectified to zero
    for (int r = 0; r <= NI; r++) for (int c = 0; c < NN; c++) wt[r][c] = -128;
    load_all(); run(-1, 0, "p1");
    // p2: negative times negative
    for (int i = 0; i < NI; i++) xin[i] = -32768;
    load_all(); run(-1, 0, "p2");
    // p3: exact clamp boundary 32767 / 32768 / -1 / 0
    for (int i = 0; i < NI; i++) xin[i] = (i == 0) ? 32767 : 0;
    for (int r = 0; r <= NI; r++) for (int c = 0; c < NN; c++) wt[r][c] = 0;
    wt[0][0] = 1; wt[0][1] = 1; wt[NI][1] = 1; wt[NI][2] = -1;
    load_all(); run(-1, 0, "p3");
    // pseudo-random sets, small and full-range inputs, with stall and busy start
    for (int p = 0; p < 12; p++) begin
      for (int i = 0; i < NI; i++)
        xin[i] = (p % 2 == 0) ? nxt(401) - 200 : nxt(65536) - 32768;
      for (int r = 0; r <= NI; r++) for (int c = 0; c < NN; c++) wt[r][c] = nxt(256) - 128;
      load_all();
      if (p == 3) begin
        // R10: in_valid while idle is ignored
        in_valid = 1'b1; in_data = 16'h4000;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R10 idle ready low", in_ready, 0);
        in_valid = 1'b0;
      end
      if (p == 5) begin
        // R2: writes past the bias row are ignored
        wr(NI + 1, 0, 99); wr(NI + 2, 3, -7);
      end
      run((p % 3 == 1) ? p % NI : -1, (p % 4 == 1), $sformatf("rnd%0d", p));
    end
    // R2: single overwrite of one weight and one bias
    wt[2][3] = 77; wr(2, 3, 77);
    wt[NI][0] = -100; wr(NI, 0, -100);
    run(-1, 0, "R2 overwrite");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule